// File: doc/BRIEF.md
# Item Price Lookup Calculator

This block works like the pricing core of a cash register. It holds a small table of retail items, each stored as a name code together with a unit price in integer cents. A caller sends commands through a valid/ready port, and every accepted command produces exactly one result.

There are two commands. A load command adds an item to the table or replaces the price of an item that is already there. A calculate command searches the table for an item name and returns the unit price multiplied by a quantity. If the name is not in the table, the error flag is raised and the subtotal is zero.

All stored names are compared against the command name at the same time. The result is registered and appears one cycle after the command is accepted. No running total is kept, so each calculation stands on its own. Reset empties the table.

Top module: `price_table_calc`

## Requirements
- R1: A load command (`cmd_op` = 0) stores `cmd_name` with `cmd_price`. A later calculate command (`cmd_op` = 1) for that name uses that price.
- R2: A calculate command on a stored name returns `res_subtotal` equal to the stored price times `cmd_qty`, exact in SUB_W = PRICE_W + QTY_W bits (for example 105 × 7 = 735, and 65535 × 255 = 16711425).
- R3: A calculate command on a name that is not stored returns `res_error` = 1 and `res_subtotal` = 0.
- R4: A calculate command on a stored name returns `res_error` = 0.
- R5: Reset empties the table, so every calculate command issued after reset reports not-found until a load is made.
- R6: Each calculation is independent of the ones before it. Repeating the same command returns the same subtotal, with no accumulation.
- R7: Loading a name that is already stored replaces its price and takes no new slot, even when the table is full. Such a load returns `res_error` = 0.
- R8: Loading a new name while all ENTRIES slots are used is rejected with `res_error` = 1. The table is left unchanged, so that name still reports not-found.
- R9: `res_valid` is high for exactly one cycle, in the cycle after each accepted command, and is low at all other times. `cmd_ready` is high whenever the block is out of reset.
- R10: A successful load returns `res_error` = 0 and `res_subtotal` = 0. A calculate command with `cmd_qty` = 0 on a stored item returns subtotal 0 with `res_error` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; empties the table |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 1 | 0 = load, 1 = calculate |
| cmd_name | input | NAME_W | Item name code |
| cmd_price | input | PRICE_W | Unit price in cents (load only) |
| cmd_qty | input | QTY_W | Quantity (calculate only) |
| res_valid | output | 1 | Result present, one cycle after acceptance |
| res_subtotal | output | PRICE_W+QTY_W | Price times quantity in cents |
| res_error | output | 1 | Name not found, or load rejected because the table is full |

## Verification
The bench builds the block with its default parameters: 8 entries, 8-bit names, 16-bit prices and 8-bit quantities. With only eight slots, the table is easy to fill, so a short test reaches both the full-table rejection path and an overwrite on a full table. Sixteen-bit prices and eight-bit quantities allow the largest product, 65535 × 255, to be checked against the full 24-bit subtotal. Eight-bit names leave plenty of unused codes, which the bench uses to test not-found lookups.

// File: rtl/price_table_calc.sv
module price_table_calc #(
  parameter int ENTRIES = 8,
  parameter int NAME_W  = 8,
  parameter int PRICE_W = 16,
  parameter int QTY_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic                       cmd_op,
  input  logic [NAME_W-1:0]          cmd_name,
  input  logic [PRICE_W-1:0]         cmd_price,
  input  logic [QTY_W-1:0]           cmd_qty,
  output logic                       res_valid,
  output logic [PRICE_W+QTY_W-1:0]   res_subtotal,
  output logic                       res_error
);
  localparam int SUB_W = PRICE_W + QTY_W;
  localparam logic OP_LOAD = 1'b0;

  logic [ENTRIES-1:0] used, hit, fresh, wr_mask;
  logic [NAME_W-1:0]  names  [ENTRIES];
  logic [PRICE_W-1:0] prices [ENTRIES];
  logic [PRICE_W-1:0] hit_price;
  logic               accept, any_hit;

  assign cmd_ready = 1'b1;
  assign accept    = cmd_valid & cmd_ready;
  assign any_hit   = |hit;
  // lowest empty slot, one-hot; zero when the table is full
  assign fresh     = ~used & (used + 1'b1);
  assign wr_mask   = any_hit ? hit : fresh;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit[i] = used[i] && (names[i] == cmd_name);
  end

  always_comb begin
    hit_price = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit[i]) hit_price = hit_price | prices[i];
  end

  always_ff @(posedge clk) begin
    if (accept && cmd_op == OP_LOAD)
      for (int i = 0; i < ENTRIES; i++)
        if (wr_mask[i]) begin
          names[i]  <= cmd_name;
          prices[i] <= cmd_price;
        end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used         <= '0;
      res_valid    <= 1'b0;
      res_error    <= 1'b0;
      res_subtotal <= '0;
    end else begin
      res_valid <= accept;
      if (accept) begin
        if (cmd_op == OP_LOAD) begin
          used         <= used | wr_mask;
          res_error    <= ~|wr_mask;
          res_subtotal <= '0;
        end else begin
          res_error    <= ~any_hit;
          res_subtotal <= any_hit ? SUB_W'(hit_price) * SUB_W'(cmd_qty) : '0;
        end
      end
    end
  end

  p_single_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
  p_result_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> res_valid);
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !res_valid);
  p_error_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_error) |-> res_subtotal == '0);
  p_full_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_op == OP_LOAD && &used && !any_hit) |=> (res_error && $stable(used)));
  p_overwrite_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_op == OP_LOAD && any_hit) |=> (!res_error && $stable(used)));
endmodule

// File: tb/price_table_calc_tb.sv
`timescale 1ns/1ps
module price_table_calc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_op = 1'b0;
  logic [7:0]  cmd_name = '0;
  logic [15:0] cmd_price = '0;
  logic [7:0]  cmd_qty = '0;
  logic        res_valid;
  logic [23:0] res_subtotal;
  logic        res_error;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [23:0] q_sub [$];
  logic        q_err [$];
  string       q_tag [$];

  int model [bit [7:0]];

  always #2 clk = ~clk;

  price_table_calc u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_name(cmd_name), .cmd_price(cmd_price), .cmd_qty(cmd_qty),
    .res_valid(res_valid), .res_subtotal(res_subtotal), .res_error(res_error)
  );

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic issue(bit op, logic [7:0] nm, logic [15:0] pr, logic [7:0] qt);
    cmd_valid = 1'b1; cmd_op = op; cmd_name = nm; cmd_price = pr; cmd_qty = qt;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_load(logic [7:0] nm, logic [15:0] pr, string tag);
    bit err;
    if (model.exists(nm)) begin model[nm] = pr; err = 0; end
    else if (model.num() < 8) begin model[nm] = pr; err = 0; end
    else err = 1;
    q_sub.push_back(24'd0); q_err.push_back(err); q_tag.push_back(tag);
    issue(1'b0, nm, pr, 8'd0);
  endtask

  task automatic do_calc(logic [7:0] nm, logic [7:0] qt, string tag);
    if (model.exists(nm)) begin
      q_sub.push_back(24'(model[nm]) * 24'(qt)); q_err.push_back(1'b0);
    end else begin
      q_sub.push_back(24'd0); q_err.push_back(1'b1);
    end
    q_tag.push_back(tag);
    issue(1'b1, nm, 16'd0, qt);
  endtask

  // monitor: compare each result against the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (q_tag.size() == 0) begin
        check(1'b0, "R9", "unexpected res_valid", 1, 0);
      end else begin
        automatic logic [23:0] es = q_sub.pop_front();
        automatic logic        ee = q_err.pop_front();
        automatic string       tg = q_tag.pop_front();
        check(res_error == ee, tg, "error", res_error, ee);
        check(res_subtotal == es, tg, "subtotal", res_subtotal, es);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_valid == 0, "R9", "res_valid after reset", res_valid, 0);
    check(cmd_ready == 1, "R9", "cmd_ready after reset", cmd_ready, 1);

    do_calc(8'h11, 8'd3, "R5");                 // empty table
    do_load(8'h11, 16'd105, "R10");             // apples
    do_calc(8'h11, 8'd7, "R2");                 // 735
    do_calc(8'h22, 8'd3, "R3");                 // oranges not loaded
    do_calc(8'h11, 8'd7, "R6");                 // same again, no accumulation
    do_calc(8'h11, 8'd0, "R10");
    do_load(8'h22, 16'd65535, "R1");
    do_calc(8'h22, 8'd255, "R2");               // 16711425
    do_calc(8'h11, 8'd1, "R4");
    do_load(8'h11, 16'd250, "R7");              // overwrite
    do_calc(8'h11, 8'd4, "R7");                 // 1000
    for (int k = 0; k < 6; k++) do_load(8'h40 + 8'(k), 16'(10 + k), "R1");
    do_load(8'h99, 16'd7, "R8");                // table full, rejected
    do_calc(8'h99, 8'd2, "R8");                 // still not found
    do_load(8'h42, 16'd500, "R7");              // overwrite while full
    do_calc(8'h42, 8'd3, "R7");
    do_calc(8'h45, 8'd2, "R1");
    do_calc(8'h22, 8'd1, "R4");
    @(negedge clk);
    check(res_valid == 0, "R9", "res_valid idle", res_valid, 0);

    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model.delete();
    do_calc(8'h11, 8'd7, "R5");
    do_calc(8'h42, 8'd1, "R5");
    do_load(8'h77, 16'd3, "R5");
    do_calc(8'h77, 8'd9, "R2");
    repeat (3) @(negedge clk);
    check(q_tag.size() == 0, "R9", "results outstanding", q_tag.size(), 0);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule